// File: doc/BRIEF.md
# Receiver Parallel Output State Controller

This block sits between a deserializer's recovered parallel word and its output pads. On each clock it decides whether the data bus, the control lines and the forwarded clock carry live data, or are parked in a fixed state. That decision depends on the power-enable input, the link-lock flag, a sleep-state select, a start-up hold strap and a software release bit. Its outputs are per-pin output-enable controls, a force-low flag, a clock-run flag for the forwarded clock, and the data and control buses, which read zero unless live.

The parked state is either high impedance (all enables low) or driven low (all enables high, every output zero, clock stopped). When the hold strap is captured high at power-up, the outputs are driven low even after lock is reached. They stay low until the release bit is seen while lock is high. Every mode change is registered, so the outputs change only on a clock edge, one edge after the inputs that caused it.

Top module: `rx_out_state_ctrl`

## Requirements
- R1: During synchronous reset and on the first edge after it, all output enables are 0, force_low is 0, clk_run is 0 and data_out/ctl_out are 0.
- R2: With pwr_en low, sleep_low_sel low and hold_strap low, the outputs are high impedance after the next edge: every enable 0, clk_run 0, force_low 0, buses 0.
- R3: With pwr_en low and sleep_low_sel high, the next edge gives driven-low outputs: every enable 1, force_low 1, clk_run 0, buses 0.
- R4: With pwr_en high and lock low, the parked state follows the same choice as R2/R3, and no input data reaches the buses.
- R5: With pwr_en and lock high and no hold in force, the edge drives the live state: every enable 1, clk_run 1, force_low 0, and data_out/ctl_out equal data_in/ctl_in as sampled at that edge.
- R6: When the hold is in force, lock high gives the driven-low state. The edge that samples hold_release=1 together with lock=1 gives the live state, and it stays live while lock holds.
- R7: When the captured hold strap is 1, the parked state is always driven low, whatever sleep_low_sel is.
- R8: hold_strap is captured at the first edge with pwr_en high after reset or after pwr_en was low. Later changes on the pin have no effect until pwr_en goes low again.
- R9: hold_release sampled while lock is low has no effect: the hold is still in force when lock later rises.
- R10: A lock loss after release gives the parked state. When lock returns, the outputs go live without a new release.
- R11: pwr_en low clears the release, so a later power-up with the strap high holds the outputs low again.
- R12: Each output value is a function of the inputs at the preceding edge and of the captured state. Outputs change only at clock edges, under any mix of inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | 1 = operate, 0 = power down |
| lock | input | 1 | Link lock status |
| sleep_low_sel | input | 1 | Parked state: 0 = high impedance, 1 = driven low |
| hold_strap | input | 1 | Start-up hold strap, captured at power-up |
| hold_release | input | 1 | Software bit that lifts the start-up hold |
| data_in | input | DW | Recovered data word |
| ctl_in | input | CW | Recovered control bits |
| data_out | output | DW | Gated data bus |
| ctl_out | output | CW | Gated control bus |
| oe_data | output | DW | Per-pin enable, data bus |
| oe_ctl | output | CW | Per-pin enable, control bus |
| oe_clk | output | 1 | Enable for the forwarded clock pin |
| clk_run | output | 1 | 1 = forwarded clock toggles, 0 = held low |
| force_low | output | 1 | 1 = outputs driven to zero |

## Verification
The release bit and a change of lock can fall in the same cycle, and so can the strap capture and the first lock-high edge after power-up. Directed steps apply the release in a lock-low cycle and then in a lock-high cycle. They also raise pwr_en, lock and the strap together, and toggle the strap pin in the cycle after capture. Random cycles then mix all five control inputs freely. Every cycle is judged against a bench model of captured strap, release state and mode, built from the requirements, with the full output vector compared away from the edge.

// File: rtl/rx_oss_pkg.sv
package rx_oss_pkg;

    typedef enum logic [1:0] {
        OM_HIZ  = 2'd0,
        OM_LOW  = 2'd1,
        OM_HOLD = 2'd2,
        OM_LIVE = 2'd3
    } out_mode_e;

    typedef struct packed {
        logic hold_eff;   // strap value in force this cycle
        logic hold_now;   // start-up hold still blocks live data
    } hold_state_t;

    function automatic out_mode_e parked_mode(input logic hold_eff, input logic low_sel);
        return (hold_eff || low_sel) ? OM_LOW : OM_HIZ;
    endfunction

    function automatic out_mode_e pick_mode(input logic pwr, input logic lk,
                                            input logic low_sel, input hold_state_t hs);
        if (!pwr || !lk)
            return parked_mode(hs.hold_eff, low_sel);
        else if (hs.hold_now)
            return OM_HOLD;
        else
            return OM_LIVE;
    endfunction

    function automatic logic mode_drives(input out_mode_e m);
        return m != OM_HIZ;
    endfunction

    function automatic logic mode_forces(input out_mode_e m);
        return (m == OM_LOW) || (m == OM_HOLD);
    endfunction

endpackage

// File: rtl/rx_strap_tracker.sv
module rx_strap_tracker
    import rx_oss_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_en,
    input  logic        lock,
    input  logic        hold_strap,
    input  logic        hold_release,
    output hold_state_t hs
);
    logic pwr_prev_q;
    logic strap_q;
    logic released_q;
    logic settled;
    logic rel_now;

    assign settled     = pwr_en & pwr_prev_q;
    assign hs.hold_eff = settled ? strap_q : hold_strap;
    assign rel_now     = pwr_en & lock & hold_release;
    assign hs.hold_now = hs.hold_eff & ~released_q & ~rel_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_prev_q <= 1'b0;
            strap_q    <= 1'b0;
            released_q <= 1'b0;
        end else begin
            pwr_prev_q <= pwr_en;
            strap_q    <= hs.hold_eff;
            if (!pwr_en)
                released_q <= 1'b0;
            else if (rel_now)
                released_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_mode_select.sv
module rx_mode_select
    import rx_oss_pkg::*;
(
    input  logic        pwr_en,
    input  logic        lock,
    input  logic        sleep_low_sel,
    input  hold_state_t hs,
    output out_mode_e   nxt
);
    always_comb nxt = pick_mode(pwr_en, lock, sleep_low_sel, hs);
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage
    import rx_oss_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  out_mode_e     nxt,
    input  logic [DW-1:0] data_in,
    input  logic [CW-1:0] ctl_in,
    output logic [DW-1:0] data_out,
    output logic [CW-1:0] ctl_out,
    output logic [DW-1:0] oe_data,
    output logic [CW-1:0] oe_ctl,
    output logic          oe_clk,
    output logic          clk_run,
    output logic          force_low
);
    out_mode_e     mode_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] ctl_q;
    logic          drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= OM_HIZ;
            data_q <= '0;
            ctl_q  <= '0;
        end else begin
            mode_q <= nxt;
            data_q <= (nxt == OM_LIVE) ? data_in : '0;
            ctl_q  <= (nxt == OM_LIVE) ? ctl_in  : '0;
        end
    end

    assign drv       = mode_drives(mode_q);
    assign force_low = mode_forces(mode_q);
    assign clk_run   = (mode_q == OM_LIVE);
    assign oe_clk    = drv;
    assign data_out  = data_q;
    assign ctl_out   = ctl_q;

    for (genvar i = 0; i < DW; i++) begin : g_oe_data
        assign oe_data[i] = drv;
    end
    for (genvar j = 0; j < CW; j++) begin : g_oe_ctl
        assign oe_ctl[j] = drv;
    end
endmodule

// File: rtl/rx_out_state_ctrl.sv
module rx_out_state_ctrl
    import rx_oss_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_en,
    input  logic          lock,
    input  logic          sleep_low_sel,
    input  logic          hold_strap,
    input  logic          hold_release,
    input  logic [DW-1:0] data_in,
    input  logic [CW-1:0] ctl_in,
    output logic [DW-1:0] data_out,
    output logic [CW-1:0] ctl_out,
    output logic [DW-1:0] oe_data,
    output logic [CW-1:0] oe_ctl,
    output logic          oe_clk,
    output logic          clk_run,
    output logic          force_low
);
    hold_state_t hs;
    out_mode_e   nxt;

    rx_strap_tracker i_strap (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .lock(lock),
        .hold_strap(hold_strap), .hold_release(hold_release), .hs(hs)
    );

    rx_mode_select i_sel (
        .pwr_en(pwr_en), .lock(lock), .sleep_low_sel(sleep_low_sel),
        .hs(hs), .nxt(nxt)
    );

    rx_out_stage #(.DW(DW), .CW(CW)) i_out (
        .clk(clk), .rst(rst), .nxt(nxt), .data_in(data_in), .ctl_in(ctl_in),
        .data_out(data_out), .ctl_out(ctl_out), .oe_data(oe_data),
        .oe_ctl(oe_ctl), .oe_clk(oe_clk), .clk_run(clk_run),
        .force_low(force_low)
    );
endmodule

// File: rtl/rx_out_state_chk.sv
module rx_out_state_chk #(
    parameter int DW = 24,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          pwr_en,
    input logic          lock,
    input logic          sleep_low_sel,
    input logic          hold_strap,
    input logic [DW-1:0] data_in,
    input logic [DW-1:0] data_out,
    input logic [DW-1:0] oe_data,
    input logic          oe_clk,
    input logic          clk_run,
    input logic          force_low
);
    // R1
    reset_parked_chk: assert property (@(posedge clk)
        rst |=> (!oe_clk && !clk_run && !force_low && data_out == '0));

    // R2
    pdn_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && !sleep_low_sel && !hold_strap) |=> (!oe_clk && oe_data == '0));

    // R3
    pdn_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwr_en && sleep_low_sel) |=> (force_low && oe_clk && data_out == '0));

    // R4
    unlocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && !lock) |=> (!clk_run && data_out == '0));

    // R5
    live_data_chk: assert property (@(posedge clk) disable iff (rst)
        clk_run |-> (data_out == $past(data_in)));

    // R6
    live_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_run) |-> ($past(lock) && $past(pwr_en)));
endmodule

bind rx_out_state_ctrl rx_out_state_chk #(.DW(DW), .CW(CW)) i_chk (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .lock(lock),
    .sleep_low_sel(sleep_low_sel), .hold_strap(hold_strap),
    .data_in(data_in), .data_out(data_out), .oe_data(oe_data),
    .oe_clk(oe_clk), .clk_run(clk_run), .force_low(force_low)
);

// File: tb/test_rx_out_state_ctrl.sv
module test_rx_out_state_ctrl;
    localparam int  DW    = 24;
    localparam int  CW    = 3;
    localparam time CLK_P = 10ns;
    localparam int  VW    = 2*DW + 2*CW + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_en = 1'b0, lock = 1'b0, sleep_low_sel = 1'b0;
    logic          hold_strap = 1'b0, hold_release = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [CW-1:0] ctl_in = '0;
    logic [DW-1:0] data_out, oe_data;
    logic [CW-1:0] ctl_out, oe_ctl;
    logic          oe_clk, clk_run, force_low;

    int n_chk = 0, n_bad = 0;

    // bench model state
    bit m_prev, m_strap, m_rel;
    int m_mode;             // 0 hi-z, 1 driven low, 2 live
    logic [DW-1:0] m_data;
    logic [CW-1:0] m_ctl;

    always #(CLK_P/2) clk = ~clk;

    rx_out_state_ctrl #(.DW(DW), .CW(CW)) i_rx_out_state_ctrl (.*);

    function automatic logic [VW-1:0] expect_vec(int mode, logic [DW-1:0] d, logic [CW-1:0] c);
        logic drv = (mode != 0);
        return {(mode == 2) ? d : '0, (mode == 2) ? c : '0,
                {DW{drv}}, {CW{drv}}, drv, mode == 2, mode == 1};
    endfunction

    task automatic check(string tag);
        logic [VW-1:0] act, exp;
        act = {data_out, ctl_out, oe_data, oe_ctl, oe_clk, clk_run, force_low};
        exp = expect_vec(m_mode, m_data, m_ctl);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit p, bit l, bit s, bit h, bit r,
                        logic [DW-1:0] d, logic [CW-1:0] c, string tag);
        bit heff, reln, hnow;
        pwr_en = p; lock = l; sleep_low_sel = s; hold_strap = h; hold_release = r;
        data_in = d; ctl_in = c;
        heff = (p && m_prev) ? m_strap : h;
        reln = p && l && r;
        hnow = heff && !m_rel && !reln;
        if (!p || !l) m_mode = (heff || s) ? 1 : 0;
        else          m_mode = hnow ? 1 : 2;
        m_data = d; m_ctl = c;
        m_prev = p; m_strap = heff;
        if (!p) m_rel = 0; else if (reln) m_rel = 1;
        @(posedge clk); @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(CLK_P*150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_prev = 0; m_strap = 0; m_rel = 0; m_mode = 0; m_data = '0; m_ctl = '0;
        check("R1");

        // power-down parked states
        step(0,0,0,0,0, 24'hABCDEF, 3'b101, "R2");
        step(0,1,0,0,0, 24'h123456, 3'b111, "R2");
        step(0,0,1,0,0, 24'hFFFFFF, 3'b111, "R3");
        step(0,1,1,0,1, 24'h00FF00, 3'b010, "R3");
        // powered, no lock
        step(1,0,1,0,0, 24'h5A5A5A, 3'b011, "R4");
        step(1,0,0,0,0, 24'hA5A5A5, 3'b100, "R4");
        // live
        step(1,1,0,0,0, 24'h000001, 3'b001, "R5");
        step(1,1,1,0,0, 24'h800000, 3'b100, "R5");
        step(1,1,0,1,0, 24'hC3C3C3, 3'b110, "R8");   // strap pin ignored once up
        step(1,1,0,0,0, 24'hFFFFFF, 3'b111, "R5");

        // power-down, then power-up with strap high and lock in the same cycle
        step(0,0,0,1,0, 24'h111111, 3'b000, "R7");
        step(1,1,0,1,0, 24'h222222, 3'b001, "R6");
        step(1,1,0,0,0, 24'h333333, 3'b010, "R8");
        step(1,0,0,0,0, 24'h444444, 3'b011, "R7");
        step(1,0,0,0,1, 24'h555555, 3'b100, "R9");
        step(1,1,0,0,0, 24'h666666, 3'b101, "R9");
        step(1,1,0,0,1, 24'h777777, 3'b110, "R6");
        step(1,1,0,0,0, 24'h888888, 3'b111, "R6");
        step(1,0,1,0,0, 24'h999999, 3'b001, "R10");
        step(1,0,0,0,0, 24'hAAAAAA, 3'b010, "R10");
        step(1,1,0,0,0, 24'hBBBBBB, 3'b011, "R10");

        // power cycle re-arms hold
        step(0,1,1,1,0, 24'hCCCCCC, 3'b100, "R11");
        step(1,1,0,1,0, 24'hDDDDDD, 3'b101, "R11");
        step(1,1,0,1,0, 24'hEEEEEE, 3'b110, "R11");

        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 16) != 0, ($urandom % 4) != 0, $urandom % 2,
                 $urandom % 2, ($urandom % 8) == 0,
                 DW'($urandom), CW'($urandom), "R12");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule